// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and its read side each run on their own clock. The two clocks may be one shared net or fully unrelated. A word enters on a write-clock edge only when both write enables are high. A word leaves on a read-clock edge only when both read enables are high. The oldest stored word is always present on the read bus, so a consumer sees the head word before it issues a read. The read bus can be released to high impedance.

Four flags report fill state. Empty is computed in the read domain and full in the write domain. The two threshold flags, almost-empty and almost-full, compare the fill level against two offset registers. Each offset resets to seven words. While the load input is high, the data ports stop moving words through the queue and give access to the two offsets instead. Enabled writes fill four 9-bit slots in a fixed rotating order, and enabled reads return those slots in the same order.

The word depth is a power-of-two parameter between 256 and 8192. Pointers cross between the domains as Gray codes through two-flop synchronizers. An asynchronous active-low reset returns the whole block to its initial state.

Top module: `prog_flag_fifo`

## Requirements
- R1: A word is stored on a rising write-clock edge exactly when wr_en_a and wr_en_b are both high, load is low and full is low. Either enable alone stores nothing.
- R2: rd_data shows the oldest stored word without any read. A read (rd_en_a and rd_en_b both high, load low, empty low) removes that word on a rising read-clock edge. Either read enable alone removes nothing.
- R3: full rises on the write edge that stores the DEPTH-th word. Writes while full are dropped, and the words read out afterwards are exactly the accepted ones, in order.
- R4: A read attempted while empty leaves the read pointer unchanged. The next word written is the next word read.
- R5: With a shared clock, empty falls after the second read-clock edge that follows the write edge of the first word. With unrelated clocks, every accepted word is read out once and in order.
- R6: almost_empty is high when the occupancy seen by the read side is at most the almost-empty offset. almost_full is high when the occupancy seen by the write side plus the almost-full offset is at least DEPTH.
- R7: With load high, each enabled write updates one offset slot instead of the queue. Slot 0 holds bits 8:0 of the almost-empty offset and slot 1 holds bits 17:9 of it. Slot 2 holds bits 8:0 of the almost-full offset and slot 3 holds bits 17:9 of it. The slot index advances 0, 1, 2, 3 and then wraps to 0.
- R8: With load high, rd_data shows the slot selected by a separate read-side index. Each enabled read advances that index in the same rotating order and removes no queue word.
- R9: When out_en is low, rd_data is high impedance. When out_en is high, rd_data is driven.
- R10: After reset, empty and almost_empty are high, full and almost_full are low, both offsets are 7, and both slot indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en_a | input | 1 | First write enable, active high |
| wr_en_b | input | 1 | Second write enable, active high |
| wr_data | input | 9 | Word to store, or offset slot value while load is high |
| full | output | 1 | Queue holds DEPTH words (write domain) |
| almost_full | output | 1 | Occupancy plus almost-full offset reaches DEPTH (write domain) |
| rd_clk | input | 1 | Read-side clock |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| out_en | input | 1 | Drives rd_data when high, releases it when low |
| rd_data | output | 9 | Head word, or selected offset slot while load is high |
| empty | output | 1 | Queue holds no word (read domain) |
| almost_empty | output | 1 | Occupancy at or below the almost-empty offset (read domain) |
| load | input | 1 | Routes enabled port accesses to the offset slots |

## Verification
The bench builds the block with DEPTH of 256, the smallest depth. A few hundred writes are then enough to reach full, to cross the default almost-full threshold at 249 words, and to cross a reprogrammed threshold at 226 words. The first half of the run ties both ports to one clock, so the synchronizer latency of R5 and each flag edge can be checked on an exact cycle. After a reset, the read clock switches to an unrelated 7 ns period. A long stream with read stalls then forces the write side into full repeatedly while the order of the data is checked.

// File: rtl/pff_pkg.sv
`timescale 1ns/1ps
package pff_pkg;
  localparam int WORD_W  = 9;
  localparam int OFS_W   = 2 * WORD_W;
  localparam int PTR_MAX = 16;

  typedef enum logic [1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } ofs_slot_e;

  function automatic logic [PTR_MAX-1:0] to_gray(input logic [PTR_MAX-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX-1:0] from_gray(input logic [PTR_MAX-1:0] g);
    logic [PTR_MAX-1:0] b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // occupancy at or below the offset
  function automatic logic near_empty(input logic [PTR_MAX-1:0] occ,
                                      input logic [OFS_W-1:0]   ofs);
    return {2'b00, occ} <= ofs;
  endfunction

  // occupancy plus offset reaches the depth
  function automatic logic near_full(input logic [PTR_MAX-1:0] occ,
                                     input logic [OFS_W-1:0]   ofs,
                                     input logic [PTR_MAX-1:0] depth);
    logic [OFS_W:0] sum;
    sum = {3'b000, occ} + {1'b0, ofs};
    return sum >= {3'b000, depth};
  endfunction

  function automatic logic [OFS_W-1:0] slot_write(input logic [OFS_W-1:0]  cur,
                                                  input logic              hi,
                                                  input logic [WORD_W-1:0] d);
    return hi ? {d, cur[WORD_W-1:0]} : {cur[OFS_W-1:WORD_W], d};
  endfunction

  function automatic logic [WORD_W-1:0] slot_read(input logic [OFS_W-1:0] v,
                                                  input logic             hi);
    return hi ? v[OFS_W-1:WORD_W] : v[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/pff_sync.sv
`timescale 1ns/1ps
module pff_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pff_wr_side.sv
`timescale 1ns/1ps
module pff_wr_side
  import pff_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int PW     = 9,
  parameter int DEF_AE = 7,
  parameter int DEF_AF = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              load,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PW-1:0]     rd_gray_s,
  output logic [PW-1:0]     wr_ptr,
  output logic [PW-1:0]     wr_gray,
  output logic [AW-1:0]     wr_addr,
  output logic              push,
  output logic              ofs_we,
  output logic [1:0]        wsel_o,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic              full,
  output logic              almost_full
);
  ofs_slot_e     wsel;
  logic          fire;
  logic [PW-1:0] rd_ptr_s;
  logic [PW-1:0] occ;
  logic [PW-1:0] wr_ptr_nx;

  assign fire      = en_a & en_b;
  assign push      = fire & ~load & ~full;
  assign ofs_we    = fire & load;
  assign rd_ptr_s  = PW'(from_gray(PTR_MAX'(rd_gray_s)));
  assign occ       = wr_ptr - rd_ptr_s;
  assign full      = (occ == PW'(DEPTH));
  assign almost_full = near_full(PTR_MAX'(occ), af_ofs, PTR_MAX'(DEPTH));
  assign wr_addr   = wr_ptr[AW-1:0];
  assign wr_ptr_nx = wr_ptr + PW'(1);
  assign wsel_o    = wsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      wr_gray <= '0;
    end else if (push) begin
      wr_ptr  <= wr_ptr_nx;
      wr_gray <= PW'(to_gray(PTR_MAX'(wr_ptr_nx)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel   <= SLOT_AE_LO;
      ae_ofs <= OFS_W'(DEF_AE);
      af_ofs <= OFS_W'(DEF_AF);
    end else if (ofs_we) begin
      unique case (wsel)
        SLOT_AE_LO, SLOT_AE_HI: ae_ofs <= slot_write(ae_ofs, wsel[0], wdata);
        SLOT_AF_LO, SLOT_AF_HI: af_ofs <= slot_write(af_ofs, wsel[0], wdata);
      endcase
      wsel <= ofs_slot_e'(wsel + 2'd1);
    end
  end
endmodule

// File: rtl/pff_rd_side.sv
`timescale 1ns/1ps
module pff_rd_side
  import pff_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              load,
  input  logic [PW-1:0]     wr_gray_s,
  input  logic [OFS_W-1:0]  ae_ofs,
  input  logic [OFS_W-1:0]  af_ofs,
  output logic [PW-1:0]     rd_ptr,
  output logic [PW-1:0]     rd_gray,
  output logic [AW-1:0]     rd_addr,
  output logic              pop,
  output logic              ofs_rd,
  output logic [WORD_W-1:0] ofs_word,
  output logic              empty,
  output logic              almost_empty
);
  ofs_slot_e     rsel;
  logic          fire;
  logic [PW-1:0] wr_ptr_s;
  logic [PW-1:0] occ;
  logic [PW-1:0] rd_ptr_nx;

  assign fire      = en_a & en_b;
  assign pop       = fire & ~load & ~empty;
  assign ofs_rd    = fire & load;
  assign wr_ptr_s  = PW'(from_gray(PTR_MAX'(wr_gray_s)));
  assign occ       = wr_ptr_s - rd_ptr;
  assign empty     = (occ == '0);
  assign almost_empty = near_empty(PTR_MAX'(occ), ae_ofs);
  assign rd_addr   = rd_ptr[AW-1:0];
  assign rd_ptr_nx = rd_ptr + PW'(1);

  always_comb begin
    unique case (rsel)
      SLOT_AE_LO, SLOT_AE_HI: ofs_word = slot_read(ae_ofs, rsel[0]);
      SLOT_AF_LO, SLOT_AF_HI: ofs_word = slot_read(af_ofs, rsel[0]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      rd_gray <= '0;
    end else if (pop) begin
      rd_ptr  <= rd_ptr_nx;
      rd_gray <= PW'(to_gray(PTR_MAX'(rd_ptr_nx)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsel <= SLOT_AE_LO;
    else if (ofs_rd) rsel <= ofs_slot_e'(rsel + 2'd1);
  end
endmodule

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
module prog_flag_fifo
  import pff_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DEF_AE = 7,
  parameter int DEF_AF = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       rst_n,
  input  logic       wr_clk,
  input  logic       wr_en_a,
  input  logic       wr_en_b,
  input  logic [8:0] wr_data,
  output logic       full,
  output logic       almost_full,
  input  logic       rd_clk,
  input  logic       rd_en_a,
  input  logic       rd_en_b,
  input  logic       out_en,
  output logic [8:0] rd_data,
  output logic       empty,
  output logic       almost_empty,
  input  logic       load
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]     wr_ptr, wr_gray, rd_ptr, rd_gray;
  logic [PW-1:0]     wr_gray_s, rd_gray_s;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic              push, pop, ofs_we, ofs_rd;
  logic [1:0]        wsel;
  logic [OFS_W-1:0]  ae_ofs, af_ofs;
  logic [WORD_W-1:0] ofs_word, head_word, bus_word;
  logic [WORD_W-1:0] mem [DEPTH];

  pff_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)) wr_i (
    .clk(wr_clk), .rst_n(rst_n), .en_a(wr_en_a), .en_b(wr_en_b), .load(load),
    .wdata(wr_data), .rd_gray_s(rd_gray_s), .wr_ptr(wr_ptr), .wr_gray(wr_gray),
    .wr_addr(wr_addr), .push(push), .ofs_we(ofs_we), .wsel_o(wsel),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .full(full), .almost_full(almost_full)
  );

  pff_rd_side #(.AW(AW), .PW(PW)) rd_i (
    .clk(rd_clk), .rst_n(rst_n), .en_a(rd_en_a), .en_b(rd_en_b), .load(load),
    .wr_gray_s(wr_gray_s), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_ptr(rd_ptr),
    .rd_gray(rd_gray), .rd_addr(rd_addr), .pop(pop), .ofs_rd(ofs_rd),
    .ofs_word(ofs_word), .empty(empty), .almost_empty(almost_empty)
  );

  pff_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_i (
    .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  pff_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_i (
    .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  always_ff @(posedge wr_clk) begin
    if (push) mem[wr_addr] <= wr_data;
  end

  assign head_word = mem[rd_addr];
  assign bus_word  = load ? ofs_word : head_word;
  assign rd_data   = out_en ? bus_word : 'z;
endmodule

// File: rtl/pff_checker.sv
`timescale 1ns/1ps
module pff_checker #(
  parameter int PW = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic          ofs_we,
  input logic [1:0]    wsel,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_gray,
  input logic          full,
  input logic          empty,
  input logic          almost_full,
  input logic          almost_empty,
  input logic [17:0]   ae_ofs,
  input logic [17:0]   af_ofs
);
  assert_push_step_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    push |=> wr_ptr == PW'($past(wr_ptr) + 1'b1));

  assert_wr_hold_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !push |=> wr_ptr == $past(wr_ptr));

  assert_pop_step_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    pop |=> rd_ptr == PW'($past(rd_ptr) + 1'b1));

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |=> wr_ptr == $past(wr_ptr));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |=> rd_ptr == $past(rd_ptr));

  assert_wr_gray_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    1'b1 |=> $onehot0(wr_gray ^ $past(wr_gray)));

  assert_rd_gray_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    1'b1 |=> $onehot0(rd_gray ^ $past(rd_gray)));

  assert_empty_near_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |-> almost_empty);

  assert_full_near_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> almost_full);

  assert_slot_step_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ofs_we |=> wsel == 2'($past(wsel) + 2'd1));

  assert_ofs_keep_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !ofs_we |=> $stable(ae_ofs) && $stable(af_ofs) && $stable(wsel));
endmodule

bind prog_flag_fifo pff_checker #(.PW(PW)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .push(push), .pop(pop),
  .ofs_we(ofs_we), .wsel(wsel), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .wr_gray(wr_gray), .rd_gray(rd_gray), .full(full), .empty(empty),
  .almost_full(almost_full), .almost_empty(almost_empty),
  .ae_ofs(ae_ofs), .af_ofs(af_ofs)
);

// File: tb/prog_flag_fifo_tb_top.sv
`timescale 1ns/1ps
module prog_flag_fifo_tb_top;
  localparam int DEPTH = 256;

  logic wr_clk = 1'b0, rd_async = 1'b0, tie = 1'b1;
  logic rst_n = 1'b0, load = 1'b0, out_en = 1'b1;
  logic wr_en_a = 1'b0, wr_en_b = 1'b0, rd_en_a = 1'b0, rd_en_b = 1'b0;
  logic [8:0] wr_data = '0;
  logic full, almost_full, empty, almost_empty;
  wire  rd_clk = tie ? wr_clk : rd_async;
  tri1 [8:0] rd_bus;

  int n_chk = 0, n_fail = 0;
  logic [8:0] expq [$];

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_async = ~rd_async;

  prog_flag_fifo #(.DEPTH(DEPTH)) dut_i (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
    .wr_data(wr_data), .full(full), .almost_full(almost_full), .rd_clk(rd_clk),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en), .rd_data(rd_bus),
    .empty(empty), .almost_empty(almost_empty), .load(load)
  );

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 11) % 512);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: waits out full, then presents one word and records it
  task automatic wr_word(input logic [8:0] d);
    @(negedge wr_clk);
    while (full) begin
      wr_en_a = 1'b0; wr_en_b = 1'b0;
      @(negedge wr_clk);
    end
    wr_en_a = 1'b1; wr_en_b = 1'b1; wr_data = d;
    expq.push_back(d);
    @(posedge wr_clk);
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_en_a = 1'b0; wr_en_b = 1'b0;
  endtask

  // monitor: compares the head word with the scoreboard, then pops it
  task automatic rd_word(input string req);
    logic [8:0] e;
    @(negedge rd_clk);
    while (empty) begin
      rd_en_a = 1'b0; rd_en_b = 1'b0;
      @(negedge rd_clk);
    end
    if (expq.size() == 0) begin
      chk(1'b0, req, int'(rd_bus), -1);
    end else begin
      e = expq.pop_front();
      chk(rd_bus == e, req, int'(rd_bus), int'(e));
    end
    rd_en_a = 1'b1; rd_en_b = 1'b1;
    @(posedge rd_clk);
  endtask

  task automatic rd_idle();
    @(negedge rd_clk);
    rd_en_a = 1'b0; rd_en_b = 1'b0;
  endtask

  task automatic ld_write(input logic [8:0] d);
    @(negedge wr_clk);
    wr_en_a = 1'b1; wr_en_b = 1'b1; wr_data = d;
    @(posedge wr_clk);
  endtask

  task automatic ld_read(input logic [8:0] e, input string req);
    @(negedge rd_clk);
    chk(rd_bus == e, req, int'(rd_bus), int'(e));
    rd_en_a = 1'b1; rd_en_b = 1'b1;
    @(posedge rd_clk);
  endtask

  task automatic do_reset(input logic tie_clk);
    @(negedge wr_clk);
    rst_n = 1'b0;
    wr_en_a = 1'b0; wr_en_b = 1'b0; rd_en_a = 1'b0; rd_en_b = 1'b0; load = 1'b0;
    tie = tie_clk;
    expq.delete();
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic check_reset_state();
    chk(empty == 1'b1, "R10 empty", int'(empty), 1);
    chk(almost_empty == 1'b1, "R10 almost_empty", int'(almost_empty), 1);
    chk(full == 1'b0, "R10 full", int'(full), 0);
    chk(almost_full == 1'b0, "R10 almost_full", int'(almost_full), 0);
    load = 1'b1;
    ld_read(9'd7, "R10 slot0"); ld_read(9'd0, "R10 slot1");
    ld_read(9'd7, "R10 slot2"); ld_read(9'd0, "R10 slot3");
    rd_idle();
    load = 1'b0;
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    check_reset_state();

    // R1: one write enable alone stores nothing
    @(negedge wr_clk); wr_en_a = 1'b1; wr_data = 9'h055;
    repeat (3) @(negedge wr_clk);
    wr_en_a = 1'b0; wr_en_b = 1'b1;
    repeat (3) @(negedge wr_clk);
    wr_en_b = 1'b0;
    repeat (4) @(negedge wr_clk);
    chk(empty == 1'b1, "R1 single enable", int'(empty), 1);

    // R5: exact crossing latency with a shared clock
    wr_word(9'h0A5);
    wr_idle();
    chk(empty == 1'b1, "R5 edge+0", int'(empty), 1);
    @(negedge rd_clk);
    chk(empty == 1'b1, "R5 edge+1", int'(empty), 1);
    @(negedge rd_clk);
    chk(empty == 1'b0, "R5 edge+2", int'(empty), 0);
    chk(rd_bus == 9'h0A5, "R2 head visible", int'(rd_bus), 'h0A5);

    // R9: released bus reads as the pull-up value
    out_en = 1'b0; #1;
    chk(rd_bus == 9'h1FF, "R9 released", int'(rd_bus), 'h1FF);
    out_en = 1'b1; #1;
    chk(rd_bus == 9'h0A5, "R9 driven", int'(rd_bus), 'h0A5);

    // R2: one read enable alone removes nothing
    @(negedge rd_clk); rd_en_a = 1'b1;
    repeat (2) @(negedge rd_clk);
    rd_en_a = 1'b0;
    chk(empty == 1'b0, "R2 single enable", int'(empty), 0);
    rd_word("R2 pop");
    rd_idle();
    chk(empty == 1'b1, "R2 empty after pop", int'(empty), 1);

    // R4: reads while empty are dropped
    @(negedge rd_clk); rd_en_a = 1'b1; rd_en_b = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_en_a = 1'b0; rd_en_b = 1'b0;
    wr_word(9'h13C);
    wr_idle();
    repeat (3) @(negedge wr_clk);
    rd_word("R4 next word");
    rd_idle();

    // R3 and R6: fill to full with default thresholds
    for (int i = 0; i < DEPTH; i++) begin
      wr_word(pat(i));
      if (i == 247 || i == 248 || i == 254 || i == 255) begin
        wr_idle();
        if (i == 247) chk(almost_full == 1'b0, "R6 af at 248", int'(almost_full), 0);
        if (i == 248) chk(almost_full == 1'b1, "R6 af at 249", int'(almost_full), 1);
        if (i == 254) chk(full == 1'b0, "R3 full at 255", int'(full), 0);
        if (i == 255) chk(full == 1'b1, "R3 full at 256", int'(full), 1);
      end
    end
    @(negedge wr_clk); wr_en_a = 1'b1; wr_en_b = 1'b1; wr_data = 9'h1FF;
    repeat (3) @(negedge wr_clk);
    wr_en_a = 1'b0; wr_en_b = 1'b0;
    chk(full == 1'b1, "R3 still full", int'(full), 1);
    repeat (3) @(negedge rd_clk);
    for (int j = 1; j <= DEPTH; j++) begin
      rd_word("R3 drain order");
      if (j == 248 || j == 249) begin
        rd_idle();
        if (j == 248) chk(almost_empty == 1'b0, "R6 ae at 8", int'(almost_empty), 0);
        if (j == 249) chk(almost_empty == 1'b1, "R6 ae at 7", int'(almost_empty), 1);
      end
    end
    rd_idle();
    chk(empty == 1'b1, "R3 empty after drain", int'(empty), 1);
    chk(expq.size() == 0, "R3 no extra word", expq.size(), 0);

    // R7 and R8: program offsets, including one wrap of the slot index
    load = 1'b1;
    ld_write(9'd5); ld_write(9'd0); ld_write(9'd30); ld_write(9'd0); ld_write(9'd20);
    wr_idle();
    repeat (3) @(negedge wr_clk);
    chk(empty == 1'b1, "R7 not queued", int'(empty), 1);
    ld_read(9'd20, "R8 slot0"); ld_read(9'd0, "R8 slot1");
    ld_read(9'd30, "R8 slot2"); ld_read(9'd0, "R8 slot3");
    ld_read(9'd20, "R8 wrap");
    rd_idle();
    load = 1'b0;
    chk(empty == 1'b1, "R8 no pop", int'(empty), 1);

    // R6 with programmed offsets 20 and 30
    for (int i = 0; i < 20; i++) wr_word(pat(i + 300));
    wr_idle();
    repeat (4) @(negedge rd_clk);
    chk(almost_empty == 1'b1, "R6 ae prog 20", int'(almost_empty), 1);
    wr_word(pat(320));
    wr_idle();
    repeat (4) @(negedge rd_clk);
    chk(almost_empty == 1'b0, "R6 ae prog 21", int'(almost_empty), 0);
    for (int i = 21; i < 225; i++) wr_word(pat(i + 300));
    wr_idle();
    chk(almost_full == 1'b0, "R6 af prog 225", int'(almost_full), 0);
    wr_word(pat(525));
    wr_idle();
    chk(almost_full == 1'b1, "R6 af prog 226", int'(almost_full), 1);
    repeat (3) @(negedge rd_clk);
    for (int j = 0; j < 226; j++) rd_word("R6 drain order");
    rd_idle();

    // R10: reset restores defaults, then unrelated clocks
    for (int i = 0; i < 3; i++) wr_word(pat(i));
    wr_idle();
    do_reset(1'b0);
    check_reset_state();

    // R5: long stream across unrelated clocks with stalls
    fork
      begin
        for (int i = 0; i < 600; i++) wr_word(pat(i + 1000));
        wr_idle();
      end
      begin
        for (int j = 0; j < 600; j++) begin
          rd_word("R5 async order");
          if (j % 150 == 0) begin
            rd_idle();
            repeat (400) @(negedge rd_clk);
          end
        end
        rd_idle();
      end
    join
    repeat (4) @(negedge rd_clk);
    chk(empty == 1'b1, "R5 async empty", int'(empty), 1);
    chk(expq.size() == 0, "R5 async count", expq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule